// File: doc/BRIEF.md
# Parallel NOR Flash Command Controller

This block models the command interface of a parallel NOR flash. It sits on a plain synchronous bus made of a byte address, a write strobe with write data, a read strobe, and an access size of one, two or four bytes. A small on-chip byte array, split into equal sectors, holds the contents and comes out of reset fully erased (every byte 0xFF).

Command bytes go in on the low byte of a bus write. A write-cycle counter and a latched command byte together make a multi-step sequencer. The sequencer performs single-word program, sector erase, buffered block write and lock handshakes. It also picks what a read returns: array data, the status register, the identifier codes or a query-table byte.

The bus has no back-pressure. Every write strobe is taken in the cycle it is high. Every read strobe gives exactly one `rvalid` pulse with its data on the next cycle. A read and a write are never issued in the same cycle.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every array byte reads 0xFF, the status register is 0x00, `err_flag` is 0, and the block is in array-read mode.
- R2: In idle, command 0x10 or 0x40 (taken from `wdata[7:0]`) arms a program. The next write stores `wdata` at `addr` with the access size (`wsize` 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes), sets status bit 7 and returns to array-read mode.
- R3: Command 0x20 erases at once the whole sector (SECTOR_BYTES bytes, aligned down) that holds `addr` to 0xFF, sets status bit 7 and waits for one more write. On that write, 0xD0 returns to idle with reads still showing status, 0xFF goes to array-read mode, and any other value is an illegal sequence.
- R4: Command 0xE8 sets status bit 7. The next write gives a count N in `wdata[7:0]`. The next N+1 writes each store data as in R2. After that, 0xD0 returns to idle with reads showing status, and any other value is an illegal sequence.
- R5: After command 0x60, a second write of 0xD0 or 0x01 sets status bit 7 and returns to idle with reads showing status. Any other value returns to array-read mode without an error.
- R6: Command 0x50 clears the status register to 0x00 and enters array-read mode. Command 0x70 selects status reads and leaves the sequencer idle. Status reads return {24'h0, status}.
- R7: After command 0x90, a read returns MFG_ID (16 bits) at index 0 and DEV_ID at index 1, and 0 at any other index. The index is `addr[7:0] >> log2(DEV_WIDTH)`.
- R8: After command 0x98, a read returns the query byte at the same index: 0x51, 0x52, 0x59 at indices 0x10 to 0x12, and ADDR_W at index 0x27. Any index at or above QUERY_LEN (0x52) returns 0. A write of 0xFF leaves query mode; any other write keeps it.
- R9: An unknown idle command or an illegal sequence returns the block to array-read mode and sets the sticky `err_flag`, which stays 1 until reset.
- R10: `rvalid` is 1 in the cycle right after each read strobe and 0 otherwise. `rdata` holds the value selected in the strobe cycle.
- R11: In array mode a read of N bytes joins bytes from `addr` upward. With BIG_ENDIAN=0 the byte at `addr` sits in bits 7:0. With BIG_ENDIAN=1 it sits in the top byte of the N-byte field, which is right-aligned in `rdata`. Writes place bytes by the same rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address of the access |
| wsize | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data; the low byte is the command byte |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, valid with `rvalid` |
| rvalid | output | 1 | High one cycle after a read strobe |
| err_flag | output | 1 | Sticky illegal-sequence flag |

## Verification
The bench goes after sector boundaries. An erase that misaligns the sector, or uses the wrong width for the sector field, would wipe a byte just outside the sector or leave one inside it. It counts the N+1 data writes of a buffered write: an off-by-one design would treat the last data word as the confirm and raise the error flag, or leave that word unstored. It checks that a bad lock value returns to array mode without raising the error, while a bad erase confirm does raise it. It also reads the query table past its length, where a design that compared with the wrong bound would return junk instead of zero. Two instances with opposite byte order take the same random writes and reads, so any lane swap shows up in one of them.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] OP_ARRAY0 = 8'h00;
  localparam logic [7:0] OP_PROG_A = 8'h10;
  localparam logic [7:0] OP_ERASE  = 8'h20;
  localparam logic [7:0] OP_PROG_B = 8'h40;
  localparam logic [7:0] OP_CLR    = 8'h50;
  localparam logic [7:0] OP_LOCK   = 8'h60;
  localparam logic [7:0] OP_STAT   = 8'h70;
  localparam logic [7:0] OP_ID     = 8'h90;
  localparam logic [7:0] OP_QUERY  = 8'h98;
  localparam logic [7:0] OP_BUF    = 8'hE8;
  localparam logic [7:0] OP_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_CONF   = 8'hD0;
  localparam logic [7:0] OP_UNLK   = 8'h01;

  typedef enum logic [1:0] {SRC_ARRAY, SRC_STATUS, SRC_ID, SRC_QUERY} rd_src_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/flash_store.sv
module flash_store #(
  parameter int ADDR_W       = 8,
  parameter int SECTOR_BYTES = 64,
  parameter bit BIG_ENDIAN   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic              erase_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [2:0]        nbytes,
  output logic [31:0]       rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SEC_W = $clog2(SECTOR_BYTES);

  logic [7:0] mem [DEPTH];
  logic [7:0] lane [4];

  // Byte for offset i of the access, picked by the configured byte order.
  always_comb begin
    for (int i = 0; i < 4; i++) begin
      lane[i] = 8'h00;
      if (i < int'(nbytes)) begin
        if (BIG_ENDIAN) lane[i] = wdata[8*(int'(nbytes)-1-i) +: 8];
        else            lane[i] = wdata[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
    end else if (erase_en) begin
      for (int j = 0; j < DEPTH; j++)
        if ((ADDR_W'(j) >> SEC_W) == (addr >> SEC_W)) mem[j] <= 8'hFF;
    end else if (prog_en) begin
      for (int i = 0; i < 4; i++)
        if (i < int'(nbytes)) mem[addr + ADDR_W'(i)] <= lane[i];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(nbytes)) begin
        if (BIG_ENDIAN) rd_data[8*(int'(nbytes)-1-i) +: 8] = mem[addr + ADDR_W'(i)];
        else            rd_data[8*i +: 8]                  = mem[addr + ADDR_W'(i)];
      end
    end
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_cmd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [1:0]  cyc,
  output logic [7:0]  cmd,
  output logic [7:0]  status,
  output logic        err,
  output logic        prog_en,
  output logic        erase_en
);
  logic [1:0]       cyc_d;
  logic [7:0]       cmd_d, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_d, bad, to_array;
  logic [7:0]       op;

  assign op       = wdata[7:0];
  assign erase_en = wr_en && (cyc == 2'd0) && (op == OP_ERASE);
  assign prog_en  = wr_en && (((cyc == 2'd1) && (cmd == OP_PROG_A || cmd == OP_PROG_B))
                              || (cyc == 2'd2));

  always_comb begin
    cyc_d = cyc; cmd_d = cmd; st_d = status; cnt_d = cnt_q; err_d = err;
    bad = 1'b0; to_array = 1'b0;
    if (wr_en) begin
      unique case (cyc)
        2'd0: case (op)
          OP_ARRAY, OP_ARRAY0: to_array = 1'b1;
          OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin cyc_d = 2'd1; cmd_d = op; end
          OP_ERASE, OP_BUF: begin cyc_d = 2'd1; cmd_d = op; st_d[7] = 1'b1; end
          OP_CLR:  begin st_d = '0; to_array = 1'b1; end
          OP_STAT, OP_ID: cmd_d = op;
          default: bad = 1'b1;
        endcase
        2'd1: case (cmd)
          OP_PROG_A, OP_PROG_B: begin st_d[7] = 1'b1; cyc_d = 2'd0; cmd_d = OP_ARRAY0; end
          OP_ERASE:
            if (op == OP_CONF) begin cyc_d = 2'd0; st_d[7] = 1'b1; end
            else if (op == OP_ARRAY) to_array = 1'b1;
            else bad = 1'b1;
          OP_BUF: begin cnt_d = wdata[CNT_W-1:0]; cyc_d = 2'd2; end
          OP_LOCK:
            if (op == OP_CONF || op == OP_UNLK) begin cyc_d = 2'd0; st_d[7] = 1'b1; end
            else to_array = 1'b1;
          OP_QUERY: if (op == OP_ARRAY) to_array = 1'b1;
          default: bad = 1'b1;
        endcase
        2'd2: begin
          st_d[7] = 1'b1;
          cnt_d   = cnt_q - 1'b1;
          if (cnt_q == '0) cyc_d = 2'd3;
        end
        2'd3:
          if (op == OP_CONF) begin cyc_d = 2'd0; st_d[7] = 1'b1; end
          else bad = 1'b1;
      endcase
    end
    if (bad || to_array) begin cyc_d = 2'd0; cmd_d = OP_ARRAY0; end
    if (bad) err_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc <= 2'd0; cmd <= OP_ARRAY0; status <= '0; cnt_q <= '0; err <= 1'b0;
    end else begin
      cyc <= cyc_d; cmd <= cmd_d; status <= st_d; cnt_q <= cnt_d; err <= err_d;
    end
  end
endmodule

// File: rtl/flash_rdmux.sv
module flash_rdmux
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          SECTOR_BYTES = 64,
  parameter int          DEV_WIDTH    = 2,
  parameter int          QUERY_LEN    = 8'h52,
  parameter logic [15:0] MFG_ID       = 16'h0089,
  parameter logic [15:0] DEV_ID       = 16'h0018
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cmd,
  input  logic [7:0]        status,
  input  logic [31:0]       arr_data,
  output logic [31:0]       rdata,
  output logic              rvalid
);
  localparam int IDX_SH = $clog2(DEV_WIDTH);
  localparam int NSECT  = (1 << ADDR_W) / SECTOR_BYTES;

  rd_src_e    src;
  logic [7:0] idx;
  logic [31:0] sel;

  function automatic logic [7:0] qbyte(input logic [7:0] i);
    if (int'(i) >= QUERY_LEN) return 8'h00;
    case (i)
      8'h10: return 8'h51;
      8'h11: return 8'h52;
      8'h12: return 8'h59;
      8'h13: return 8'h01;
      8'h15: return 8'h31;
      8'h1B: return 8'h45;
      8'h1C: return 8'h55;
      8'h27: return 8'(ADDR_W);
      8'h28: return 8'h02;
      8'h2C: return 8'h01;
      8'h2D: return 8'(NSECT - 1);
      8'h2E: return 8'((NSECT - 1) >> 8);
      8'h2F: return 8'(SECTOR_BYTES >> 8);
      8'h30: return 8'(SECTOR_BYTES >> 16);
      default: return 8'h00;
    endcase
  endfunction

  assign idx = addr[7:0] >> IDX_SH;

  always_comb begin
    case (cmd)
      OP_ID:    src = SRC_ID;
      OP_QUERY: src = SRC_QUERY;
      OP_ERASE, OP_CLR, OP_LOCK, OP_STAT, OP_BUF: src = SRC_STATUS;
      default:  src = SRC_ARRAY;
    endcase
    unique case (src)
      SRC_ARRAY:  sel = arr_data;
      SRC_STATUS: sel = {24'h0, status};
      SRC_ID:     sel = (idx == 8'd0) ? {16'h0, MFG_ID} :
                        (idx == 8'd1) ? {16'h0, DEV_ID} : 32'h0;
      SRC_QUERY:  sel = {24'h0, qbyte(idx)};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= sel;
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          SECTOR_BYTES = 64,
  parameter int          DEV_WIDTH    = 2,
  parameter int          QUERY_LEN    = 8'h52,
  parameter int          CNT_W        = 8,
  parameter bit          BIG_ENDIAN   = 1'b0,
  parameter logic [15:0] MFG_ID       = 16'h0089,
  parameter logic [15:0] DEV_ID       = 16'h0018
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wsize,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  input  logic              rd_en,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic              err_flag
);
  logic [1:0]  seq_cyc;
  logic [7:0]  seq_cmd, seq_status;
  logic        prog_en, erase_en;
  logic [31:0] arr_data;
  logic [2:0]  nbytes;

  assign nbytes = size_bytes(wsize);

  flash_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
    .cyc(seq_cyc), .cmd(seq_cmd), .status(seq_status), .err(err_flag),
    .prog_en(prog_en), .erase_en(erase_en)
  );

  flash_store #(.ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES), .BIG_ENDIAN(BIG_ENDIAN)) u_store (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .erase_en(erase_en),
    .addr(addr), .wdata(wdata), .nbytes(nbytes), .rd_data(arr_data)
  );

  flash_rdmux #(.ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES), .DEV_WIDTH(DEV_WIDTH),
                .QUERY_LEN(QUERY_LEN), .MFG_ID(MFG_ID), .DEV_ID(DEV_ID)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .cmd(seq_cmd),
    .status(seq_status), .arr_data(arr_data), .rdata(rdata), .rvalid(rvalid)
  );
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic        rvalid,
  input logic        err_flag,
  input logic [31:0] wdata,
  input logic [1:0]  cyc,
  input logic [7:0]  cmd,
  input logic [7:0]  status
);
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid); // R10
  AST_RVALID_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R9
  AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cyc == 2'd0 && wdata[7:0] == 8'h50) |=> (status == 8'h00 && cmd == 8'h00)); // R6
  AST_STATUS_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cyc == 2'd0 && wdata[7:0] == 8'h70) |=> (cyc == 2'd0 && cmd == 8'h70)); // R6
  AST_ERASE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cyc == 2'd0 && wdata[7:0] == 8'h20) |=> (status[7] && cyc == 2'd1)); // R3
  AST_BUF_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (cmd == 8'hE8)); // R4
endmodule

bind flash_cmd_ctrl flash_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rvalid(rvalid),
  .err_flag(err_flag), .wdata(wdata), .cyc(seq_cyc), .cmd(seq_cmd), .status(seq_status)
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  wsize = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata0, rdata1;
  logic        rvalid0, rvalid1, err0, err1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] m0 [256];
  logic [7:0] m1 [256];

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.BIG_ENDIAN(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wsize(wsize), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata0), .rvalid(rvalid0), .err_flag(err0));
  flash_cmd_ctrl #(.BIG_ENDIAN(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wsize(wsize), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata1), .rvalid(rvalid1), .err_flag(err1));

  function automatic int nb(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_le(input logic [7:0] a, input logic [1:0] sz);
    logic [31:0] r = '0;
    for (int i = 0; i < nb(sz); i++) r[8*i +: 8] = m0[8'(a + i)];
    return r;
  endfunction

  function automatic logic [31:0] exp_be(input logic [7:0] a, input logic [1:0] sz);
    logic [31:0] r = '0;
    for (int i = 0; i < nb(sz); i++) r[8*(nb(sz)-1-i) +: 8] = m1[8'(a + i)];
    return r;
  endfunction

  task automatic model_prog(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
    for (int i = 0; i < nb(sz); i++) begin
      m0[8'(a + i)] = d[8*i +: 8];
      m1[8'(a + i)] = d[8*(nb(sz)-1-i) +: 8];
    end
  endtask

  task automatic model_erase(input logic [7:0] a);
    for (int j = 0; j < 256; j++)
      if (j / 64 == int'(a) / 64) begin m0[j] = 8'hFF; m1[j] = 8'hFF; end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    addr = a; wdata = d; wsize = sz; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] sz,
                    output logic [31:0] r0, output logic [31:0] r1);
    @(negedge clk);
    addr = a; wsize = sz; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    r0 = rdata0; r1 = rdata1;
    chk("R10 rvalid after read", {30'h0, rvalid1, rvalid0}, 32'h3);
  endtask

  task automatic rd_both(input string req, input logic [7:0] a, input logic [1:0] sz,
                         input logic [31:0] e0, input logic [31:0] e1);
    logic [31:0] r0, r1;
    rd(a, sz, r0, r1);
    chk(req, r0, e0);
    chk(req, r1, e1);
  endtask

  task automatic rd_array(input string req, input logic [7:0] a, input logic [1:0] sz);
    rd_both(req, a, sz, exp_le(a, sz), exp_be(a, sz));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int j = 0; j < 256; j++) begin m0[j] = 8'hFF; m1[j] = 8'hFF; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 err after reset", {31'h0, err0 | err1}, 32'h0);
    @(negedge clk);
    chk("R10 rvalid idle", {30'h0, rvalid1, rvalid0}, 32'h0);
    rd_array("R1 erased array", 8'h10, 2'd2);
    wr(8'h00, 32'hAB00_0070, 2'd0);
    rd_both("R1 R6 status zero", 8'h00, 2'd0, 32'h0, 32'h0);
    wr(8'h00, 32'h0000_00FF, 2'd0);

    // R2 R11: directed programs, all sizes
    wr(8'h20, 32'hAB00_0040, 2'd0); wr(8'h20, 32'h1122_3344, 2'd2); model_prog(8'h20, 32'h1122_3344, 2'd2);
    rd_both("R11 word order", 8'h20, 2'd2, 32'h1122_3344, 32'h1122_3344);
    rd_both("R11 byte at addr", 8'h20, 2'd0, 32'h44, 32'h11);
    rd_array("R11 halfword", 8'h21, 2'd1);
    wr(8'hFF, 32'h0000_0010, 2'd0); wr(8'hFF, 32'h0000_A5B6, 2'd1); model_prog(8'hFF, 32'hA5B6, 2'd1);
    rd_array("R2 wrap program", 8'hFE, 2'd2);
    wr(8'h00, 32'h0000_0070, 2'd0);
    rd_both("R2 ready bit", 8'h00, 2'd0, 32'h80, 32'h80);
    wr(8'h00, 32'h0000_0050, 2'd0);
    rd_array("R6 clear returns to array", 8'h20, 2'd2);
    wr(8'h00, 32'h0000_0070, 2'd0);
    rd_both("R6 status cleared", 8'h00, 2'd0, 32'h0, 32'h0);
    wr(8'h00, 32'h0000_0000, 2'd0);

    // R3: erase with neighbours on both sides of sector 1
    wr(8'h3F, 32'h40, 2'd0); wr(8'h3F, 32'h3C, 2'd0); model_prog(8'h3F, 32'h3C, 2'd0);
    wr(8'h40, 32'h40, 2'd0); wr(8'h40, 32'h5A, 2'd0); model_prog(8'h40, 32'h5A, 2'd0);
    wr(8'h7F, 32'h40, 2'd0); wr(8'h7F, 32'h6B, 2'd0); model_prog(8'h7F, 32'h6B, 2'd0);
    wr(8'h80, 32'h40, 2'd0); wr(8'h80, 32'h7C, 2'd0); model_prog(8'h80, 32'h7C, 2'd0);
    wr(8'h00, 32'h50, 2'd0);
    wr(8'h55, 32'h20, 2'd0); model_erase(8'h55);
    rd_both("R3 status during erase", 8'h00, 2'd0, 32'h80, 32'h80);
    wr(8'h55, 32'hD0, 2'd0);
    rd_both("R3 status after confirm", 8'h00, 2'd0, 32'h80, 32'h80);
    wr(8'h00, 32'hFF, 2'd0);
    rd_both("R3 sector start erased", 8'h40, 2'd0, 32'hFF, 32'hFF);
    rd_both("R3 sector end erased", 8'h7F, 2'd0, 32'hFF, 32'hFF);
    rd_both("R3 below sector kept", 8'h3F, 2'd0, 32'h3C, 32'h3C);
    rd_both("R3 above sector kept", 8'h80, 2'd0, 32'h7C, 32'h7C);
    wr(8'h90, 32'h20, 2'd0); model_erase(8'h90); wr(8'h90, 32'hFF, 2'd0);
    rd_array("R3 abort to array", 8'h80, 2'd2);

    // R5: lock handshakes, no error
    wr(8'h00, 32'h50, 2'd0);
    wr(8'h00, 32'h60, 2'd0); wr(8'h00, 32'h01, 2'd0);
    rd_both("R5 unlock ready", 8'h00, 2'd0, 32'h80, 32'h80);
    wr(8'h00, 32'h60, 2'd0); wr(8'h00, 32'h55, 2'd0);
    rd_array("R5 bad lock value to array", 8'h20, 2'd2);
    chk("R5 no error on bad lock", {31'h0, err0 | err1}, 32'h0);

    // R4: buffered write, N=2 gives three data words
    wr(8'h00, 32'hE8, 2'd0);
    wr(8'h00, 32'h02, 2'd0);
    wr(8'hC0, 32'hDEAD_BEEF, 2'd2); model_prog(8'hC0, 32'hDEAD_BEEF, 2'd2);
    wr(8'hC4, 32'h0BAD_F00D, 2'd2); model_prog(8'hC4, 32'h0BAD_F00D, 2'd2);
    wr(8'hC8, 32'hCAFE_0123, 2'd2); model_prog(8'hC8, 32'hCAFE_0123, 2'd2);
    wr(8'h00, 32'hD0, 2'd0);
    chk("R4 no error at confirm", {31'h0, err0 | err1}, 32'h0);
    rd_both("R4 status after confirm", 8'h00, 2'd0, 32'h80, 32'h80);
    wr(8'h00, 32'hFF, 2'd0);
    rd_array("R4 first word", 8'hC0, 2'd2);
    rd_both("R4 last word", 8'hC8, 2'd2, 32'hCAFE_0123, 32'hCAFE_0123);

    // R7: identifier reads
    wr(8'h00, 32'h90, 2'd0);
    rd_both("R7 manufacturer", 8'h00, 2'd1, 32'h0089, 32'h0089);
    rd_both("R7 device", 8'h02, 2'd1, 32'h0018, 32'h0018);
    rd_both("R7 other index", 8'h04, 2'd1, 32'h0, 32'h0);
    wr(8'h00, 32'hFF, 2'd0);

    // R8: query table
    wr(8'h00, 32'h98, 2'd0);
    rd_both("R8 query Q", 8'h20, 2'd0, 32'h51, 32'h51);
    rd_both("R8 query Y", 8'h24, 2'd0, 32'h59, 32'h59);
    rd_both("R8 size byte", 8'h4E, 2'd0, 32'h08, 32'h08);
    rd_both("R8 past length", 8'hA4, 2'd0, 32'h0, 32'h0);
    rd_both("R8 far index", 8'hFE, 2'd0, 32'h0, 32'h0);
    wr(8'h00, 32'h12, 2'd0);
    rd_both("R8 stays in query", 8'h22, 2'd0, 32'h52, 32'h52);
    wr(8'h00, 32'hFF, 2'd0);
    rd_array("R8 leave query", 8'hC4, 2'd2);

    // R2 R11: random programs, erases and reads
    for (int k = 0; k < 300; k++) begin
      int op;
      logic [7:0] a;
      logic [1:0] sz;
      logic [31:0] d;
      op = int'($urandom_range(0, 7));
      a  = 8'($urandom);
      sz = 2'($urandom_range(0, 2));
      d  = $urandom;
      if (op < 3) begin
        wr(a, {24'h0, (op == 0) ? 8'h10 : 8'h40}, 2'd0);
        wr(a, d, sz); model_prog(a, d, sz);
      end else if (op == 3) begin
        wr(a, 32'h20, 2'd0); model_erase(a); wr(a, 32'hD0, 2'd0); wr(a, 32'hFF, 2'd0);
      end else begin
        rd_array("R2 R11 random read", a, sz);
      end
    end

    // R9: illegal sequences
    wr(8'h00, 32'h20, 2'd0); model_erase(8'h00); wr(8'h00, 32'h33, 2'd0);
    chk("R9 bad erase confirm flags", {30'h0, err1, err0}, 32'h3);
    rd_array("R9 back to array", 8'h00, 2'd2);
    wr(8'h00, 32'h77, 2'd0);
    rd_array("R9 unknown command", 8'hC0, 2'd2);
    wr(8'h00, 32'h50, 2'd0);
    chk("R9 flag sticky", {30'h0, err1, err0}, 32'h3);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule